// File: doc/BRIEF.md
# Atomic Register-Memory Exchange Sequencer

This block performs an atomic exchange between one memory location and a value supplied by the requester. A request carries a byte address, the value to store and a byte-or-word select. The sequencer reads the old contents of the location and then writes the new value to the same address. It returns the old contents as its result. From the read through the write it holds a bus lock output, so that no other master can reach the shared memory between the two accesses.

Its main use is spin-lock acquisition. Software exchanges the value 1 into a lock word. If the old value returned is 1, the lock was already held and the requester tries again. If the old value is 0, the requester now owns the lock.

The memory port is a simple synchronous one. A request with the write enable low is a read, and its data appears on `mem_rdata_i` one cycle later. A request with the write enable high is a write, qualified per byte lane by `mem_be_o`. The memory accepts every request in the cycle it is presented.

Top module: `swap_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, and `lock_o`, `mem_req_o`, `mem_we_o` and `done_o` are 0.
- R2: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the cycle after acceptance until the sequencer is idle again. A request offered while `req_ready_o` is 0 has no effect on the exchange in progress or on memory.
- R3: In the cycle after acceptance, the block issues a read (`mem_req_o`=1, `mem_we_o`=0) at the accepted address, with `lock_o`=1.
- R4: In the next cycle, the block issues a write (`mem_req_o`=1, `mem_we_o`=1) to the same address, with `lock_o` still 1.
- R5: `lock_o` is 1 exactly during the read cycle and the write cycle, with no gap between them. It is 0 in the done cycle and whenever the block is idle.
- R6: `done_o` is a one-cycle pulse, three cycles after the acceptance edge. In that cycle `result_o` carries the old memory contents.
- R7: Word mode (`req_byte_i`=0): `mem_be_o`=4'b1111, `mem_wdata_o` is the supplied value, and afterwards the memory word holds the supplied value.
- R8: Byte mode (`req_byte_i`=1): only the byte lane chosen by address bits [1:0] is enabled (lane 0 = bits 7:0, `mem_be_o` bit n = lane n). The low byte of the supplied value is placed on every lane of `mem_wdata_o`. The result is the old byte of that lane, zero-extended to 32 bits, and the other lanes of the word are unchanged.
- R9: Exchanging 1 into a word that already holds 1 returns 1. Exchanging 1 into a word that holds 0 returns 0 and leaves 1 in memory.
- R10: `mem_req_o` is never 1 while `lock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Exchange request offered |
| req_ready_o | output | 1 | Sequencer idle, request will be taken |
| req_addr_i | input | 16 | Byte address of the location |
| req_wdata_i | input | 32 | Value to store |
| req_byte_i | input | 1 | 1 = byte exchange, 0 = word exchange |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Old memory contents, valid with done_o |
| lock_o | output | 1 | Holds the shared memory bus |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read |

## Verification
Take the acceptance edge as cycle zero. The read strobe is due one cycle later, the write with its lanes and data two cycles later, and `done_o` with the old value three cycles later. `lock_o` is due high exactly in the read and write cycles. The bench steps a behavioural model of phase, captured request and shadow memory at every rising edge. It compares every output against that model at every falling edge, so a value that arrives one cycle early or late fails in the cycle where it differs. At each done cycle the bench also compares the memory contents written through the port against the shadow memory.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOCK_READ = 2'd1,
    ST_WRITE     = 2'd2,
    ST_DONE      = 2'd3
  } swap_state_e;
endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_rd_o,
  output logic lock_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic done_o
);
  swap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid_i) state_d = ST_LOCK_READ;
      ST_LOCK_READ: state_d = ST_WRITE;
      ST_WRITE:     state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign accept_o     = ready_o && req_valid_i;
  // lock spans read and write only; dropped on entry to DONE
  assign lock_o       = (state_q == ST_LOCK_READ) || (state_q == ST_WRITE);
  assign mem_req_o    = lock_o;
  assign mem_we_o     = (state_q == ST_WRITE);
  assign capture_rd_o = (state_q == ST_WRITE);
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/swap_lane.sv
module swap_lane #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] result_o
);
  logic [7:0] rd_byte;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_o[g]          = !byte_i || (lane_i == LANE_W'(g));
    assign wdata_o[8*g +: 8] = byte_i ? wdata_i[7:0] : wdata_i[8*g +: 8];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_i == LANE_W'(i)) rd_byte = rdata_i[8*i +: 8];
    end
  end

  assign result_o = byte_i ? {{(DATA_W-8){1'b0}}, rd_byte} : rdata_i;
endmodule

// File: rtl/swap_seq.sv
module swap_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_byte_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              accept, capture_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, ext_rd, result_q;
  logic              byte_q;

  swap_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .ready_o      (req_ready_o),
    .accept_o     (accept),
    .capture_rd_o (capture_rd),
    .lock_o       (lock_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .done_o       (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      byte_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      data_q <= req_wdata_i;
      byte_q <= req_byte_i;
    end
  end

  swap_lane #(.DATA_W(DATA_W)) i_lane (
    .lane_i   (addr_q[LANE_W-1:0]),
    .byte_i   (byte_q),
    .wdata_i  (data_q),
    .rdata_i  (mem_rdata_i),
    .be_o     (mem_be_o),
    .wdata_o  (mem_wdata_o),
    .result_o (ext_rd)
  );

  // read data of the locked read lands during the write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         result_q <= '0;
    else if (capture_rd) result_q <= ext_rd;
  end

  assign mem_addr_o = addr_q;
  assign result_o   = result_q;
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              lock_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_be_o
);
  a_r10_req_under_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lock_o);

  a_r4_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o && lock_o));

  a_r4_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_addr_o == $past(mem_addr_o)));

  a_r5_lock_off_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> done_o);

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o || done_o) |-> !req_ready_o);

  a_r8_lane_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || mem_be_o == '1));
endmodule

bind swap_seq swap_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_swap_seq.sv
module test_swap_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_byte = 1'b0;
  logic        done, lock, mem_req, mem_we;
  logic [31:0] result, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];

  // model state
  int          ph = 0;
  logic [15:0] m_addr;
  logic [31:0] m_data, m_res;
  logic        m_byte;

  always #5 clk = ~clk;

  swap_seq i_swap_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_byte_i(req_byte),
    .done_o(done), .result_o(result), .lock_o(lock),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // memory driven by the design
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  // reference model
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
        logic [31:0] old;
        int ln;
        m_addr = req_addr; m_data = req_wdata; m_byte = req_byte;
        old = ref_mem[req_addr[9:2]];
        ln = int'(req_addr[1:0]);
        if (req_byte) begin
          m_res = (old >> (8*ln)) & 32'hff;
          ref_mem[req_addr[9:2]][8*ln +: 8] = req_wdata[7:0];
        end else begin
          m_res = old;
          ref_mem[req_addr[9:2]] = req_wdata;
        end
        ph = 1;
      end
      1: ph = 2;
      2: ph = 3;
      default: ph = 0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0]  e_be;
      logic [31:0] e_wd;
      e_be = m_byte ? (4'b1 << m_addr[1:0]) : 4'hf;
      e_wd = m_byte ? {4{m_data[7:0]}} : m_data;
      chk(req_ready == (ph == 0), "R2 ready", 32'(req_ready), 32'(ph == 0));
      chk(lock == (ph == 1 || ph == 2), "R5 lock", 32'(lock), 32'(ph == 1 || ph == 2));
      chk(mem_req == (ph == 1 || ph == 2), "R10 mem_req", 32'(mem_req), 32'(ph == 1 || ph == 2));
      chk(mem_we == (ph == 2), "R4 mem_we", 32'(mem_we), 32'(ph == 2));
      chk(done == (ph == 3), "R6 done", 32'(done), 32'(ph == 3));
      if (ph == 1) chk(mem_addr == m_addr, "R3 read addr", 32'(mem_addr), 32'(m_addr));
      if (ph == 2) begin
        chk(mem_addr == m_addr, "R4 write addr", 32'(mem_addr), 32'(m_addr));
        chk(mem_be == e_be, m_byte ? "R8 be" : "R7 be", 32'(mem_be), 32'(e_be));
        chk(mem_wdata == e_wd, m_byte ? "R8 wdata" : "R7 wdata", mem_wdata, e_wd);
      end
      if (ph == 3) begin
        chk(result == m_res, m_byte ? "R8 result" : "R6 result", result, m_res);
        chk(mem[m_addr[9:2]] == ref_mem[m_addr[9:2]], m_byte ? "R8 mem" : "R7 mem",
            mem[m_addr[9:2]], ref_mem[m_addr[9:2]]);
      end
    end
  end

  task automatic swap(input logic [15:0] a, input logic [31:0] d, input bit by);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #1;
    req_valid = 1; req_addr = a; req_wdata = d; req_byte = by;
    @(negedge clk); #1;
    req_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h0101_0000 * i[31:0] ^ 32'hA5C3_0F96;
      ref_mem[i] = mem[i];
    end
    mem[4] = 32'h1111_2222; ref_mem[4] = 32'h1111_2222;
    mem[8] = 32'h0;         ref_mem[8] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready", 32'(req_ready), 1);
    chk(!lock && !mem_req && !mem_we && !done, "R1 idle outputs",
        32'({lock, mem_req, mem_we, done}), 0);
    #1 rst_n = 1;
    // R7 word exchange
    swap(16'h0010, 32'h1234_5678, 0);
    chk(mem[4] == 32'h1234_5678, "R7 word stored", mem[4], 32'h1234_5678);
    // R8 each byte lane
    for (int l = 0; l < 4; l++) swap(16'h0040 + 16'(l), 32'hCAFE_0090 + 32'(l), 1);
    // R9 test-and-set
    swap(16'h0020, 32'h1, 0);
    chk(result == 32'h0, "R9 first grab", result, 0);
    swap(16'h0020, 32'h1, 0);
    chk(result == 32'h1, "R9 already taken", result, 1);
    // R2 request held during busy: junk on inputs while exchange runs
    @(negedge clk); #1;
    req_valid = 1; req_addr = 16'h0080; req_wdata = 32'hDEAD_BEEF; req_byte = 0;
    @(negedge clk); #1;
    req_addr = 16'h0084; req_wdata = 32'h0BAD_F00D; req_byte = 1;
    repeat (2) @(negedge clk);
    chk(mem[33] == ref_mem[33], "R2 busy ignored", mem[33], ref_mem[33]);
    repeat (5) @(negedge clk); #1;
    req_valid = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 40; k++)
      swap(16'($urandom_range(0, 1023)), $urandom, bit'($urandom_range(0, 1)));
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule